// File: doc/BRIEF.md
# Bidirectional latched bus transceiver

This block sits between two eight-bit ports, A and B. It holds one storage register for each direction of data flow. The A-to-B path takes data from port A into its store and presents that store on port B. The B-to-A path works the same way from B to A. Each direction has three active-low controls of its own. A chip select gates both data entry and output drive. A load strobe opens the store to new data. A drive strobe turns on the output. Because each direction has its own controls, software or a sequencer can run the two directions independently. One direction can take in data while the other holds and drives.

The storage is level-sensitive in intent but is modelled in a synthesizable sampled form. While the store is open, it takes the input port value at every rising clock edge, so it follows the input with one cycle of latency. When the load strobe goes high, the store keeps the last value it sampled. Tri-state behaviour is represented by a data output and an enable output on each port. A flag reports when both directions drive their ports at once.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While rst_n is low, a_oe and b_oe are 0. After reset both stores read 0, so a_out and b_out are 0 until new data is loaded.
- R2: At a rising clock edge where ab_chip_n=0 and ab_load_n=0, the A-to-B store takes a_in. b_out shows that value after the edge, so a changing a_in is followed cycle by cycle.
- R3: At an edge where ab_load_n=1, the A-to-B store keeps its value whatever a_in does.
- R4: At an edge where ab_chip_n=1, the A-to-B store keeps its value even when ab_load_n=0.
- R5: Outside reset, b_oe is 1 exactly when ab_chip_n=0 and ab_drive_n=0, in the same cycle the controls are applied. b_out always presents the A-to-B store.
- R6: Turning the output off, with ab_drive_n=1 or ab_chip_n=1, does not change the stored value. The old value reappears on b_out when the drive is turned back on.
- R7: The B-to-A direction follows R2 to R6 using b_in, ba_chip_n, ba_load_n and ba_drive_n, and presents its store on a_out with enable a_oe.
- R8: contention is 1 exactly when a_oe and b_oe are both 1, and is 0 otherwise.
- R9: Loading or driving in one direction never changes the store of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 8 | Value seen on port A |
| a_out | output | 8 | Data presented to port A (B-to-A store) |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | 8 | Value seen on port B |
| b_out | output | 8 | Data presented to port B (A-to-B store) |
| b_oe | output | 1 | Port B drive enable |
| ab_chip_n | input | 1 | A-to-B chip select, active low |
| ab_load_n | input | 1 | A-to-B load strobe, active low |
| ab_drive_n | input | 1 | A-to-B drive strobe, active low |
| ba_chip_n | input | 1 | B-to-A chip select, active low |
| ba_load_n | input | 1 | B-to-A load strobe, active low |
| ba_drive_n | input | 1 | B-to-A drive strobe, active low |
| contention | output | 1 | Both ports driven at once |

## Verification
A corrupt store shows up on the data output of its port right after the clock edge that corrupts it. It stays visible on every later cycle, until a load that is sampled at an edge overwrites it. An enable error shows up in the same cycle as the controls that cause it, because the enables are not registered. Hold checks therefore alternate closed strobes with fresh input values. A write that leaks through shows up on the next sample, and turning the drive off and on again shows whether the stored value survived.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
  localparam int N_DIR  = 2;

  typedef struct packed {
    logic chip_n;
    logic load_n;
    logic drive_n;
  } dir_ctrl_t;

  // store accepts new data only with chip and load both low
  function automatic logic entry_open(input dir_ctrl_t c);
    return !c.chip_n && !c.load_n;
  endfunction

  // port is driven only with chip and drive both low
  function automatic logic drive_open(input dir_ctrl_t c);
    return !c.chip_n && !c.drive_n;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             open_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (open_i) q_o <= din_i;
  end

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctrl_t        ctrl_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             oe_o
);

  logic             capture_evt;
  logic             drive_evt;
  logic [WIDTH-1:0] store_q;

  assign capture_evt = entry_open(ctrl_i);
  assign drive_evt   = drive_open(ctrl_i);

  xcvr_store #(.WIDTH(WIDTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (capture_evt),
    .din_i  (src_i),
    .q_o    (store_q)
  );

  assign dout_o = store_q;
  assign oe_o   = rst_n && drive_evt;

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_i.chip_n && !ctrl_i.load_n) |=> (dout_o == $past(src_i))); // R2
  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.chip_n || ctrl_i.load_n) |=> $stable(dout_o)); // R3
  AST_DRIVE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i.chip_n || ctrl_i.drive_n) |-> !oe_o); // R5

endmodule

// File: rtl/xcvr_clash.sv
module xcvr_clash
  import xcvr_pkg::*;
(
  input  logic [N_DIR-1:0] drive_i,
  output logic             clash_o
);

  assign clash_o = &drive_i;

endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  input  logic             ab_chip_n,
  input  logic             ab_load_n,
  input  logic             ab_drive_n,
  input  logic             ba_chip_n,
  input  logic             ba_load_n,
  input  logic             ba_drive_n,
  output logic             contention
);

  dir_ctrl_t              ctrl [N_DIR];
  logic [N_DIR-1:0][WIDTH-1:0] src;
  logic [N_DIR-1:0][WIDTH-1:0] dst;
  logic [N_DIR-1:0]       drv;

  assign ctrl[DIR_AB] = '{chip_n: ab_chip_n, load_n: ab_load_n, drive_n: ab_drive_n};
  assign ctrl[DIR_BA] = '{chip_n: ba_chip_n, load_n: ba_load_n, drive_n: ba_drive_n};
  assign src[DIR_AB]  = a_in;
  assign src[DIR_BA]  = b_in;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    xcvr_dir #(.WIDTH(WIDTH)) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .ctrl_i (ctrl[d]),
      .src_i  (src[d]),
      .dout_o (dst[d]),
      .oe_o   (drv[d])
    );
  end

  assign b_out = dst[DIR_AB];
  assign b_oe  = drv[DIR_AB];
  assign a_out = dst[DIR_BA];
  assign a_oe  = drv[DIR_BA];

  xcvr_clash u_clash (
    .drive_i (drv),
    .clash_o (contention)
  );

  AST_CLASH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    contention |-> (!ab_chip_n && !ab_drive_n && !ba_chip_n && !ba_drive_n)); // R8
  AST_AB_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_chip_n || ab_load_n) |=> $stable(b_out)); // R9
  AST_BA_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_chip_n || ba_load_n) |=> $stable(a_out)); // R7

endmodule

// File: tb/bidir_latch_xcvr_tb_top.sv
`timescale 1ns/1ps
module bidir_latch_xcvr_tb_top;

  localparam int W = 8;

  typedef struct {
    string      tag;
    logic [W-1:0] a_out;
    logic       a_oe;
    logic [W-1:0] b_out;
    logic       b_oe;
    logic       cont;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic a_oe, b_oe, contention;
  logic ab_chip_n = 1'b0, ab_load_n = 1'b0, ab_drive_n = 1'b0;
  logic ba_chip_n = 1'b0, ba_load_n = 1'b0, ba_drive_n = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb_q[$];
  logic [W-1:0] m_ab = '0, m_ba = '0;

  always #4 clk = ~clk;

  bidir_latch_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_chip_n(ab_chip_n), .ab_load_n(ab_load_n), .ab_drive_n(ab_drive_n),
    .ba_chip_n(ba_chip_n), .ba_load_n(ba_load_n), .ba_drive_n(ba_drive_n),
    .contention(contention)
  );

  // driver: apply one cycle of stimulus and push the expected port state
  task automatic step(input logic [W-1:0] av, input logic [W-1:0] bv,
                      input logic [2:0] ab, input logic [2:0] ba, input string tag);
    exp_t e;
    @(negedge clk);
    a_in = av; b_in = bv;
    {ab_chip_n, ab_load_n, ab_drive_n} = ab;
    {ba_chip_n, ba_load_n, ba_drive_n} = ba;
    if (!ab[2] && !ab[1]) m_ab = av;
    if (!ba[2] && !ba[1]) m_ba = bv;
    e.tag   = tag;
    e.b_out = m_ab;
    e.a_out = m_ba;
    e.b_oe  = !ab[2] && !ab[0];
    e.a_oe  = !ba[2] && !ba[0];
    e.cont  = e.a_oe && e.b_oe;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (a_out !== e.a_out || a_oe !== e.a_oe || b_out !== e.b_out ||
            b_oe !== e.b_oe || contention !== e.cont) begin
          bad++;
          $display("FAIL %s: got a=%h/%b b=%h/%b c=%b exp a=%h/%b b=%h/%b c=%b",
                   e.tag, a_out, a_oe, b_out, b_oe, contention,
                   e.a_out, e.a_oe, e.b_out, e.b_oe, e.cont);
        end
      end
    end
  end

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 5000);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    wrap_up();
  end

  // control encodings {chip_n, load_n, drive_n}
  localparam logic [2:0] LOAD_HIDE  = 3'b001;
  localparam logic [2:0] LOAD_SHOW  = 3'b000;
  localparam logic [2:0] HOLD_SHOW  = 3'b010;
  localparam logic [2:0] HOLD_HIDE  = 3'b011;
  localparam logic [2:0] CHIP_OFF   = 3'b100;

  initial begin
    // R1: reset with all controls enabled keeps outputs quiet
    a_in = 8'hA5; b_in = 8'h5A;
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (a_oe !== 1'b0 || b_oe !== 1'b0 || a_out !== '0 || b_out !== '0 || contention !== 1'b0) begin
      bad++;
      $display("FAIL R1: got a=%h/%b b=%h/%b exp 00/0 00/0", a_out, a_oe, b_out, b_oe);
    end
    @(negedge clk);
    {ab_chip_n, ab_load_n, ab_drive_n} = 3'b111;
    {ba_chip_n, ba_load_n, ba_drive_n} = 3'b111;
    rst_n = 1'b1;
    step(8'hA5, 8'h5A, HOLD_HIDE, HOLD_HIDE, "R1 post-reset store zero");

    // R2: loading and following
    step(8'h5A, 8'h00, LOAD_HIDE, HOLD_HIDE, "R2 load hidden");
    step(8'h11, 8'h00, HOLD_SHOW, HOLD_HIDE, "R2 show loaded");
    for (int i = 0; i < 6; i++)
      step(8'(i * 37 + 3), 8'h00, LOAD_SHOW, HOLD_HIDE, "R2 follow");
    step(8'h5A, 8'h00, LOAD_SHOW, HOLD_HIDE, "R2 reload");

    // R3: load strobe high holds
    step(8'hFF, 8'h00, HOLD_SHOW, HOLD_HIDE, "R3 hold");
    step(8'h00, 8'h00, HOLD_SHOW, HOLD_HIDE, "R3 hold new input");

    // R4: chip off blocks entry even with load low
    step(8'h33, 8'h00, 3'b100, HOLD_HIDE, "R4 chip off load low");
    step(8'h44, 8'h00, 3'b101, HOLD_HIDE, "R4 chip off");
    step(8'h55, 8'h00, HOLD_SHOW, HOLD_HIDE, "R4 value kept");

    // R5 / R6: drive gating keeps content
    step(8'h66, 8'h00, HOLD_HIDE, HOLD_HIDE, "R5 drive off");
    step(8'h66, 8'h00, CHIP_OFF | 3'b011, HOLD_HIDE, "R6 chip off");
    step(8'h66, 8'h00, HOLD_SHOW, HOLD_HIDE, "R6 drive back");

    // R7: B-to-A direction
    step(8'h00, 8'hC3, HOLD_HIDE, LOAD_HIDE, "R7 load");
    step(8'h00, 8'h3C, HOLD_HIDE, HOLD_SHOW, "R7 show");
    step(8'h00, 8'h99, HOLD_HIDE, 3'b100, "R7 chip off load low");
    step(8'h00, 8'h99, HOLD_HIDE, HOLD_SHOW, "R7 kept");
    for (int i = 0; i < 4; i++)
      step(8'h00, 8'(200 - i * 13), HOLD_HIDE, LOAD_SHOW, "R7 follow");

    // R9: one direction busy, other holds
    step(8'h0F, 8'hF0, LOAD_HIDE, HOLD_HIDE, "R9 ab load ba hold");
    step(8'hE1, 8'h1E, HOLD_HIDE, LOAD_HIDE, "R9 ba load ab hold");
    step(8'h00, 8'h00, HOLD_SHOW, HOLD_HIDE, "R9 ab shown");

    // R8: contention only when both drive
    step(8'h00, 8'h00, HOLD_SHOW, HOLD_SHOW, "R8 both drive");
    step(8'h00, 8'h00, HOLD_SHOW, HOLD_HIDE, "R8 one drives");
    step(8'h00, 8'h00, HOLD_HIDE, HOLD_SHOW, "R8 other drives");

    repeat (3) @(posedge clk);
    #3;
    wrap_up();
  end

endmodule